// File: doc/BRIEF.md
# Staged Configuration Register Bank for a Data Converter

This block holds the byte-wide control settings of a data converter behind a plain address/data port. A serial control decoder upstream turns its bit stream into single-cycle write strobes with an 8-bit address and 8-bit data. Reads are combinational from the same address bus. The decoder is not part of this block.

Settings for the converter functions are written first into staging copies. Software can read these back at once, but the converter does not see them yet. The active copies that drive the outputs change only when software writes a 1 to the commit bit of the commit register. All staged values then move across on the same clock edge. The interface register is not staged: its bit-order control takes effect on the write. Its soft-reset control is duplicated in both nibbles, like the bit-order control, so it decodes the same way whichever shift order the decoder uses.

An external power-down input overrides the staged power field. A control bit in the mode register picks which low-power state the pin selects.

Top module: `cfg_bank`

## Requirements
- R1: After the synchronous reset `rst`: address 0x00 reads 0x18, address 0x08 reads 0x00, address 0x2A reads 0x01, `pwr_mode` is 0 (normal), `lsb_first` is 0 and `ovr_en` is 1.
- R2: Address 0x01 reads the identifier parameter (default 0x6C). Address 0x02 reads the speed-grade code in bits [4:3], with the other bits 0 (default code 00, giving 0x00). Writes to either address change nothing.
- R3: A write that sets bit 5 or bit 2 of address 0x00 restores every register to its reset value, both staged and active copies, on the next clock edge. After that, both bits read 0.
- R4: `lsb_first` is the OR of bits 6 and 1 of address 0x00 and follows a write to that address with no commit. In that register, bits 4 and 3 always read 1, and bits 7 and 0 always read 0.
- R5: Writes to 0x08 and 0x2A are visible on read-back at once. They leave `pwr_mode` and `ovr_en` unchanged until a commit.
- R6: Writing address 0xFF with bit 0 = 1 copies all staged registers into the active registers on that write's clock edge. Writing it with bit 0 = 0 copies nothing. Address 0xFF always reads 0x00.
- R7: With `ext_pd` low, the active power field (bits [2:0] of 0x08) maps as follows on `pwr_mode`: 000 and 011 give normal (0), 001 gives full power-down (1), 010 gives standby (2), and 1xx gives normal (0).
- R8: With `ext_pd` high, `pwr_mode` is 1 (full power-down) when active bit 5 of 0x08 is 0, and 2 (standby) when it is 1, whatever the power field holds.
- R9: `ovr_en` equals active bit 0 of 0x2A.
- R10: Only bit 5 and bits [2:0] of 0x08 and bit 0 of 0x2A can be written; the other bits read 0. Unmapped addresses read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 8 | Register address for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| ext_pd | input | 1 | External power-down request, overrides the register field |
| pwr_mode | output | 2 | Active power state: 0 normal, 1 full power-down, 2 standby |
| lsb_first | output | 1 | Serial bit-order select for the upstream decoder |
| ovr_en | output | 1 | Overrange output enable |

## Verification
A table of writes, each followed by a read-back, tries every mapped, read-only and unmapped address with all-ones and sparse patterns. This separates the per-register write masks, the fixed-one bits and the ignored addresses. Directed sequences then stage a value and probe the outputs before and after a commit, so a bank that writes straight through is caught. Every power code is run with the pin low and both pin-select values with the pin high, which separates pin priority from field decoding. Soft reset is triggered from each nibble on its own and compared against a hard reset.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

    localparam int DW = 8;
    localparam int AW = 8;

    localparam logic [AW-1:0] A_PORT  = 8'h00;
    localparam logic [AW-1:0] A_IDENT = 8'h01;
    localparam logic [AW-1:0] A_GRADE = 8'h02;
    localparam logic [AW-1:0] A_MODES = 8'h08;
    localparam logic [AW-1:0] A_OVR   = 8'h2A;
    localparam logic [AW-1:0] A_XFER  = 8'hFF;

    // writable bits and fixed-one bits per register
    localparam logic [DW-1:0] PORT_WMASK  = 8'h66;
    localparam logic [DW-1:0] PORT_FIXED1 = 8'h18;
    localparam logic [DW-1:0] MODES_WMASK = 8'h27;
    localparam logic [DW-1:0] OVR_WMASK   = 8'h01;

    localparam logic [DW-1:0] MODES_RST = 8'h00;
    localparam logic [DW-1:0] OVR_RST   = 8'h01;

    typedef enum logic [1:0] {
        PM_NORMAL  = 2'd0,
        PM_FULL    = 2'd1,
        PM_STANDBY = 2'd2
    } pwr_mode_e;

    typedef struct packed {
        logic [DW-1:0] modes;
        logic [DW-1:0] ovr;
    } stage_t;

    typedef struct packed {
        logic port;
        logic modes;
        logic ovr;
        logic commit;
    } wsel_t;

    localparam stage_t STAGE_RST = '{modes: MODES_RST, ovr: OVR_RST};

    function automatic pwr_mode_e field_to_mode(input logic [2:0] code);
        case (code)
            3'b001:  return PM_FULL;
            3'b010:  return PM_STANDBY;
            default: return PM_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/cfg_bank_wsel.sv
module cfg_bank_wsel
    import cfg_bank_pkg::*;
(
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output wsel_t         sel
);
    always_comb begin
        sel        = '0;
        sel.port   = wr_en && (addr == A_PORT);
        sel.modes  = wr_en && (addr == A_MODES);
        sel.ovr    = wr_en && (addr == A_OVR);
        sel.commit = wr_en && (addr == A_XFER) && wdata[0];
    end
endmodule

// File: rtl/cfg_bank_pwr.sv
module cfg_bank_pwr
    import cfg_bank_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] modes_act,
    input  logic          ext_pd,
    output pwr_mode_e     mode
);
    always_comb begin
        if (ext_pd)
            mode = modes_act[5] ? PM_STANDBY : PM_FULL;
        else
            mode = field_to_mode(modes_act[2:0]);
    end

    // R8: the pin never leaves the converter in normal operation
    a_r8_pin_wins: assert property (@(posedge clk) disable iff (rst)
        ext_pd |-> (mode != PM_NORMAL));
endmodule

// File: rtl/cfg_bank_rdmux.sv
module cfg_bank_rdmux
    import cfg_bank_pkg::*;
#(
    parameter logic [DW-1:0] CHIP_ID     = 8'h6C,
    parameter logic [1:0]    SPEED_GRADE = 2'b00
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] port_q,
    input  stage_t        staged,
    output logic [DW-1:0] rdata
);
    always_comb begin
        case (addr)
            A_PORT:  rdata = (port_q & PORT_WMASK) | PORT_FIXED1;
            A_IDENT: rdata = CHIP_ID;
            A_GRADE: rdata = {3'b000, SPEED_GRADE, 3'b000};
            A_MODES: rdata = staged.modes & MODES_WMASK;
            A_OVR:   rdata = staged.ovr & OVR_WMASK;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
    import cfg_bank_pkg::*;
#(
    parameter logic [7:0] CHIP_ID     = 8'h6C,
    parameter logic [1:0] SPEED_GRADE = 2'b00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       ext_pd,
    output logic [1:0] pwr_mode,
    output logic       lsb_first,
    output logic       ovr_en
);
    wsel_t         sel;
    logic [DW-1:0] port_q;
    stage_t        staged_q;
    stage_t        active_q;
    logic          soft_req;
    pwr_mode_e     mode;

    cfg_bank_wsel u_wsel (
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .sel   (sel)
    );

    // either mirrored nibble can request the soft reset
    assign soft_req = port_q[5] | port_q[2];

    always_ff @(posedge clk) begin
        if (rst || soft_req) begin
            port_q   <= '0;
            staged_q <= STAGE_RST;
            active_q <= STAGE_RST;
        end else begin
            if (sel.port)   port_q         <= wdata & PORT_WMASK;
            if (sel.modes)  staged_q.modes <= wdata & MODES_WMASK;
            if (sel.ovr)    staged_q.ovr   <= wdata & OVR_WMASK;
            if (sel.commit) active_q       <= staged_q;
        end
    end

    cfg_bank_rdmux #(
        .CHIP_ID     (CHIP_ID),
        .SPEED_GRADE (SPEED_GRADE)
    ) u_rdmux (
        .addr   (addr),
        .port_q (port_q),
        .staged (staged_q),
        .rdata  (rdata)
    );

    cfg_bank_pwr u_pwr (
        .clk       (clk),
        .rst       (rst),
        .modes_act (active_q.modes),
        .ext_pd    (ext_pd),
        .mode      (mode)
    );

    assign pwr_mode  = mode;
    assign lsb_first = port_q[6] | port_q[1];
    assign ovr_en    = active_q.ovr[0];

    // R3: a soft-reset request is gone one edge later
    a_r3_soft_clears: assert property (@(posedge clk) disable iff (rst)
        soft_req |=> !(port_q[5] || port_q[2]));

    // R6: a commit moves the staged image across whole
    a_r6_commit_copies: assert property (@(posedge clk) disable iff (rst)
        (sel.commit && !soft_req) |=> (active_q == $past(staged_q)));

    // R5: without a commit or soft reset the active image holds
    a_r5_active_holds: assert property (@(posedge clk) disable iff (rst)
        (!sel.commit && !soft_req) |=> $stable(active_q));

    // R6: the commit register never reads back as set
    a_r6_commit_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (addr == A_XFER) |-> (rdata == 8'h00));

endmodule

// File: tb/tb_cfg_bank.sv
module tb_cfg_bank;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       ext_pd;
    logic [1:0] pwr_mode;
    logic       lsb_first;
    logic       ovr_en;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    cfg_bank dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .ext_pd    (ext_pd),
        .pwr_mode  (pwr_mode),
        .lsb_first (lsb_first),
        .ovr_en    (ovr_en)
    );

    // {address, write data, expected read-back}
    localparam int NV = 10;
    localparam logic [23:0] VEC [NV] = '{
        24'h00_42_5A,   // R4 mirrored bit order, fixed ones
        24'h00_81_18,   // R4 bits 7 and 0 not writable
        24'h08_FF_27,   // R10 mode register mask
        24'h08_D8_00,   // R10 reserved bits only
        24'h2A_FE_00,   // R10 overrange mask
        24'h2A_FF_01,   // R10
        24'h01_00_6C,   // R2 identifier ignores write
        24'h02_FF_00,   // R2 grade ignores write
        24'h10_AB_00,   // R10 unmapped
        24'hFF_00_00    // R6 commit register reads 0
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic commit();
        wr(8'hFF, 8'h01);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0; ext_pd = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_check("R1 port", 8'h00, 8'h18);
        rd_check("R1 modes", 8'h08, 8'h00);
        rd_check("R1 ovr", 8'h2A, 8'h01);
        check("R1 pwr_mode", {6'd0, pwr_mode}, 8'd0);
        check("R1 lsb_first", {7'd0, lsb_first}, 8'd0);
        check("R1 ovr_en", {7'd0, ovr_en}, 8'd1);

        // register table walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][23:16], VEC[i][15:8]);
            rd_check("R10 table", VEC[i][23:16], VEC[i][7:0]);
        end

        // R10 unmapped write leaves mapped registers alone
        wr(8'h09, 8'hFF);
        rd_check("R10 neighbour", 8'h08, 8'h00);

        do_reset();
        // R5 staging
        wr(8'h08, 8'h01);
        rd_check("R5 staged readback", 8'h08, 8'h01);
        check("R5 not yet active", {6'd0, pwr_mode}, 8'd0);
        commit();
        check("R6 commit applies", {6'd0, pwr_mode}, 8'd1);
        rd_check("R6 reads zero", 8'hFF, 8'h00);

        // R7 every code
        for (int c = 0; c < 8; c++) begin
            logic [1:0] e;
            e = (c == 1) ? 2'd1 : (c == 2) ? 2'd2 : 2'd0;
            wr(8'h08, 8'(c));
            commit();
            check("R7 code", {6'd0, pwr_mode}, {6'd0, e});
        end

        // R8 pin override
        ext_pd = 1'b1;
        wr(8'h08, 8'h20);
        commit();
        #1 check("R8 pin standby", {6'd0, pwr_mode}, 8'd2);
        wr(8'h08, 8'h02);
        commit();
        #1 check("R8 pin full", {6'd0, pwr_mode}, 8'd1);
        ext_pd = 1'b0;
        #1 check("R7 pin released", {6'd0, pwr_mode}, 8'd2);

        // R9 overrange enable
        wr(8'h2A, 8'h00);
        check("R5 ovr staged only", {7'd0, ovr_en}, 8'd1);
        commit();
        check("R9 ovr off", {7'd0, ovr_en}, 8'd0);
        wr(8'h2A, 8'h01);
        wr(8'hFF, 8'hFE);
        check("R6 bit0 clear no copy", {7'd0, ovr_en}, 8'd0);
        commit();
        check("R9 ovr on", {7'd0, ovr_en}, 8'd1);

        // R4 bit order each nibble
        wr(8'h00, 8'h02);
        check("R4 low nibble", {7'd0, lsb_first}, 8'd1);
        wr(8'h00, 8'h40);
        check("R4 high nibble", {7'd0, lsb_first}, 8'd1);
        wr(8'h00, 8'h00);
        check("R4 cleared", {7'd0, lsb_first}, 8'd0);

        // R3 soft reset from low nibble
        wr(8'h00, 8'h42);
        wr(8'h08, 8'h02);
        wr(8'h2A, 8'h00);
        commit();
        wr(8'h00, 8'h04);
        @(negedge clk);
        rd_check("R3 port default", 8'h00, 8'h18);
        rd_check("R3 staged modes", 8'h08, 8'h00);
        rd_check("R3 staged ovr", 8'h2A, 8'h01);
        check("R3 active mode", {6'd0, pwr_mode}, 8'd0);
        check("R3 active ovr", {7'd0, ovr_en}, 8'd1);
        check("R3 lsb_first", {7'd0, lsb_first}, 8'd0);

        // R3 soft reset from high nibble
        wr(8'h08, 8'h01);
        commit();
        wr(8'h00, 8'h20);
        @(negedge clk);
        rd_check("R3 high port", 8'h00, 8'h18);
        check("R3 high mode", {6'd0, pwr_mode}, 8'd0);

        // R1 hard reset after changes
        wr(8'h2A, 8'h00);
        commit();
        wr(8'h00, 8'h42);
        do_reset();
        rd_check("R1 port again", 8'h00, 8'h18);
        check("R1 ovr_en again", {7'd0, ovr_en}, 8'd1);
        check("R1 lsb again", {7'd0, lsb_first}, 8'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule